// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Overrun Tracking

This block takes in 8-bit asynchronous frames on a single serial line. A frame is one low start bit, eight data bits sent least significant bit first, an optional parity bit, and one stop bit. The line is idle high. The block synchronises the line into its clock domain and waits for it to go low. When it does, it starts a bit timer that belongs to that frame alone, checks the start bit again at its middle, and then samples every later bit at the middle of its bit period.

When the stop bit is sampled, the received byte moves into the data register. The block then raises a completion flag, an error flag, or both. A pending flag inside the block remembers that a byte is waiting for software. Software marks the byte as consumed by pulsing the re-arm input. If a new frame ends while the pending flag is still set, the result is an overrun: the block reports it on the error flag and does not raise the completion flag. Each flag stays set until software clears it with a write-1-to-clear pulse.

Top module: `async_rx_ovr`

## Requirements
- R1: A frame is a start bit (0), then data bits D0 to D7 with D0 first, then a parity bit only while `par_en` is 1, then one stop bit. Every frame that completes loads its byte into `rx_data`, visible the cycle after the stop bit is sampled. `rx_data` changes at no other time.
- R2: The line passes through `SYNC_STAGES` flip-flops. If the line falls just before clock edge 1, the start bit is confirmed at edge `SYNC_STAGES+1+HALF`, where HALF is `CLKS_PER_BIT/2`. Each later bit is sampled `CLKS_PER_BIT` edges after the one before it. Without parity, `done_flag` therefore first reads 1 after edge `SYNC_STAGES+1+HALF+9*CLKS_PER_BIT`.
- R3: If the synchronised line is high again when the start bit is re-checked, the event is a glitch. It is ignored: no flag changes and no data is loaded.
- R4: A frame that ends while the pending flag is clear sets `done_flag`.
- R5: With `par_en`=1, the parity bit makes the XOR of the data and parity bits equal to `par_odd` (0 = even, 1 = odd). A mismatch sets `par_err` and `err_flag` together with `done_flag`.
- R6: A stop bit sampled as 0 sets `frm_err` and `err_flag` together with `done_flag`.
- R7: Every completed frame sets the pending flag, and a `rearm` pulse clears it. A frame that ends while the pending flag is set sets `ovr_err` and `err_flag` and leaves `done_flag` unchanged.
- R8: A `rearm` pulse in the same cycle that the stop bit is sampled still counts as an overrun, and the pending flag stays set.
- R9: Each `flag_clr` bit clears one flag: bit 0 `done_flag`, bit 1 `err_flag`, bit 2 `par_err`, bit 3 `frm_err`, bit 4 `ovr_err`. If a set and a clear land in the same cycle, the set wins.
- R10: While `rx_en` is 0, the line is ignored and the bit timer stays stopped. Dropping `rx_en` in the middle of a frame abandons that frame.
- R11: After reset, all flags, the pending flag and `rx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable |
| par_en | input | 1 | A parity bit follows D7 |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| rx_line | input | 1 | Serial input, idle high |
| rearm | input | 1 | One-cycle pulse that clears the pending flag |
| flag_clr | input | 5 | Write-1-to-clear mask for the five flags |
| rx_data | output | 8 | Last received byte |
| done_flag | output | 1 | Receive-complete flag |
| err_flag | output | 1 | Receive-error flag |
| par_err | output | 1 | Parity error seen |
| frm_err | output | 1 | Framing error seen |
| ovr_err | output | 1 | Overrun seen |

## Verification
The bench builds the block with `CLKS_PER_BIT`=8 and `SYNC_STAGES`=2. With these values a frame lasts 80 to 88 cycles, so many frames fit in a short run. Frames also run back to back, which makes the overrun path easy to reach. The small, known bit period lets the bench place a `rearm` or `flag_clr` pulse on the exact stop-sample cycle. It can also measure the start-to-flag latency in R2 as an exact edge count.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

    localparam int DATA_W = 8;
    localparam int FLAG_W = 5;

    // flag vector bit positions, shared by flag_clr and the status register
    localparam int FL_DONE = 0;
    localparam int FL_ERR  = 1;
    localparam int FL_PAR  = 2;
    localparam int FL_FRM  = 3;
    localparam int FL_OVR  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              par_bit;
        logic              stop_bit;
    } rx_frame_t;

    // 1 when the data and parity bits break the selected parity rule
    function automatic logic par_mismatch(input logic [DATA_W-1:0] d,
                                          input logic p,
                                          input logic odd);
        return (^d) ^ p ^ odd;
    endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b1;
                    else     chain_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b1;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
    import async_rx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      par_en,
    input  logic      s,
    output logic      done,
    output rx_frame_t frame
);
    localparam int HALF = CLKS_PER_BIT / 2;
    localparam int CW   = $clog2(CLKS_PER_BIT);
    localparam int NW   = $clog2(DATA_W);

    rx_state_e         state_q;
    logic [CW-1:0]     cnt_q;
    logic [NW-1:0]     nbit_q;
    logic [DATA_W-1:0] sh_q;
    logic              pbit_q;
    logic              bit_end, half_end;

    assign bit_end  = (cnt_q == CW'(CLKS_PER_BIT - 1));
    assign half_end = (cnt_q == CW'(HALF - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            nbit_q  <= '0;
            sh_q    <= '0;
            pbit_q  <= 1'b0;
        end else if (!en) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (!s) state_q <= ST_START;
                end
                ST_START: begin
                    if (half_end) begin
                        cnt_q  <= '0;
                        nbit_q <= '0;
                        state_q <= s ? ST_IDLE : ST_DATA;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (bit_end) begin
                        cnt_q <= '0;
                        sh_q  <= {s, sh_q[DATA_W-1:1]};
                        if (nbit_q == NW'(DATA_W - 1))
                            state_q <= par_en ? ST_PAR : ST_STOP;
                        else
                            nbit_q <= nbit_q + 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (bit_end) begin
                        cnt_q   <= '0;
                        pbit_q  <= s;
                        state_q <= ST_STOP;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (bit_end) begin
                        cnt_q   <= '0;
                        state_q <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done           = en && (state_q == ST_STOP) && bit_end;
    assign frame.data     = sh_q;
    assign frame.par_bit  = pbit_q;
    assign frame.stop_bit = s;

    // R3: a start bit that is high again at its mid-point is dropped
    p_glitch_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (en && state_q == ST_START && half_end && s) |=> (state_q == ST_IDLE));

    // R10: disabled receiver holds its timer idle
    p_disable_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !en |=> (state_q == ST_IDLE && cnt_q == '0));

    // R2: the bit timer never runs past one bit period
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        (cnt_q <= CW'(CLKS_PER_BIT - 1)));
endmodule

// File: rtl/rx_status.sv
module rx_status
    import async_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  rx_frame_t         frame,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              rearm,
    input  logic [FLAG_W-1:0] clr,
    output logic [DATA_W-1:0] data_q,
    output logic [FLAG_W-1:0] flags_q
);
    logic              pend_q;
    logic              ovr_hit, perr, ferr;
    logic [FLAG_W-1:0] set_v;

    always_comb begin
        ovr_hit = done && pend_q;
        perr    = done && par_en && par_mismatch(frame.data, frame.par_bit, par_odd);
        ferr    = done && !frame.stop_bit;
        set_v          = '0;
        set_v[FL_DONE] = done && !ovr_hit;
        set_v[FL_ERR]  = ovr_hit || perr || ferr;
        set_v[FL_PAR]  = perr;
        set_v[FL_FRM]  = ferr;
        set_v[FL_OVR]  = ovr_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            pend_q  <= 1'b0;
            flags_q <= '0;
        end else begin
            if (done) data_q <= frame.data;
            if (done)       pend_q <= 1'b1;
            else if (rearm) pend_q <= 1'b0;
            flags_q <= (flags_q & ~clr) | set_v;
        end
    end

    // R7: each finished frame leaves the pending flag set
    p_pend_set_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> pend_q);

    // R7: overrun reports an error and never a completion
    p_ovr_no_done_r7: assert property (@(posedge clk) disable iff (rst)
        (done && pend_q && !flags_q[FL_DONE]) |=> (!flags_q[FL_DONE] && flags_q[FL_OVR] && flags_q[FL_ERR]));

    // R4: a frame with nothing pending raises completion
    p_done_set_r4: assert property (@(posedge clk) disable iff (rst)
        (done && !pend_q) |=> flags_q[FL_DONE]);

    // R6: low stop bit marks a framing error
    p_frm_r6: assert property (@(posedge clk) disable iff (rst)
        (done && !frame.stop_bit) |=> (flags_q[FL_FRM] && flags_q[FL_ERR]));

    // R8: re-arm coinciding with the stop sample is still an overrun
    p_rearm_race_r8: assert property (@(posedge clk) disable iff (rst)
        (done && rearm && pend_q) |=> (flags_q[FL_OVR] && pend_q));

    // R1: data register only moves on a completed frame
    p_data_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(data_q));
endmodule

// File: rtl/async_rx_ovr.sv
module async_rx_ovr
    import async_rx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_en,
    input  logic        par_en,
    input  logic        par_odd,
    input  logic        rx_line,
    input  logic        rearm,
    input  logic [4:0]  flag_clr,
    output logic [7:0]  rx_data,
    output logic        done_flag,
    output logic        err_flag,
    output logic        par_err,
    output logic        frm_err,
    output logic        ovr_err
);
    logic              line_s;
    logic              frame_done;
    rx_frame_t         frame;
    logic [FLAG_W-1:0] flags;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_line),
        .dout (line_s)
    );

    rx_frame #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_frame (
        .clk    (clk),
        .rst    (rst),
        .en     (rx_en),
        .par_en (par_en),
        .s      (line_s),
        .done   (frame_done),
        .frame  (frame)
    );

    rx_status u_status (
        .clk     (clk),
        .rst     (rst),
        .done    (frame_done),
        .frame   (frame),
        .par_en  (par_en),
        .par_odd (par_odd),
        .rearm   (rearm),
        .clr     (flag_clr),
        .data_q  (rx_data),
        .flags_q (flags)
    );

    assign done_flag = flags[FL_DONE];
    assign err_flag  = flags[FL_ERR];
    assign par_err   = flags[FL_PAR];
    assign frm_err   = flags[FL_FRM];
    assign ovr_err   = flags[FL_OVR];
endmodule

// File: tb/async_rx_ovr_test.sv
`timescale 1ns/1ps
module async_rx_ovr_test;
    localparam int DIV  = 8;
    localparam int SYNC = 2;
    localparam int HALF = DIV / 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst = 1'b1, rx_en = 1'b0, par_en = 1'b0, par_odd = 1'b0;
    logic       rx_line = 1'b1, rearm = 1'b0;
    logic [4:0] flag_clr = '0;
    logic [7:0] rx_data;
    logic       done_flag, err_flag, par_err, frm_err, ovr_err;

    async_rx_ovr #(.CLKS_PER_BIT(DIV), .SYNC_STAGES(SYNC)) uut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .par_en(par_en), .par_odd(par_odd),
        .rx_line(rx_line), .rearm(rearm), .flag_clr(flag_clr), .rx_data(rx_data),
        .done_flag(done_flag), .err_flag(err_flag), .par_err(par_err),
        .frm_err(frm_err), .ovr_err(ovr_err)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // phase: 0 idle, 1 start check, 2 data, 3 parity, 4 stop
    int         m_phase = 0, m_cnt = 0, m_nbit = 0;
    logic [7:0] m_sh = 0, m_data = 0;
    logic       m_pbit = 0, m_pend = 0;
    logic [4:0] m_fl = 0;
    logic       m_syn [SYNC];

    always @(posedge clk) begin : model
        logic s, fin, stopb, ovr, pe, fe;
        logic [4:0] setv;
        fin = 0; stopb = 1; setv = 0;
        if (rst) begin
            m_phase = 0; m_cnt = 0; m_nbit = 0; m_sh = 0; m_data = 0;
            m_pbit = 0; m_pend = 0; m_fl = 0;
            for (int i = 0; i < SYNC; i++) m_syn[i] = 1'b1;
        end else begin
            s = m_syn[SYNC-1];
            if (!rx_en) begin
                m_phase = 0; m_cnt = 0;
            end else if (m_phase == 0) begin
                m_cnt = 0;
                if (!s) m_phase = 1;
            end else if (m_phase == 1) begin
                if (m_cnt == HALF - 1) begin
                    m_cnt = 0; m_nbit = 0;
                    m_phase = s ? 0 : 2;
                end else m_cnt++;
            end else if (m_cnt == DIV - 1) begin
                m_cnt = 0;
                if (m_phase == 2) begin
                    m_sh = {s, m_sh[7:1]};
                    if (m_nbit == 7) m_phase = par_en ? 3 : 4;
                    else m_nbit++;
                end else if (m_phase == 3) begin
                    m_pbit = s; m_phase = 4;
                end else begin
                    fin = 1; stopb = s; m_phase = 0;
                end
            end else m_cnt++;

            if (fin) begin
                ovr = m_pend;
                pe  = par_en && ((^m_sh) ^ m_pbit ^ par_odd);
                fe  = !stopb;
                setv = {ovr, fe, pe, ovr | pe | fe, !ovr};
                m_data = m_sh;
            end
            m_fl = (m_fl & ~flag_clr) | setv;
            if (fin) m_pend = 1;
            else if (rearm) m_pend = 0;
            for (int i = SYNC - 1; i > 0; i--) m_syn[i] = m_syn[i-1];
            m_syn[0] = rx_line;
        end
        cyc++;
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check("R1 rx_data",   rx_data,   m_data);
            check("R4 done_flag", done_flag, m_fl[0]);
            check("R7 err_flag",  err_flag,  m_fl[1]);
            check("R5 par_err",   par_err,   m_fl[2]);
            check("R6 frm_err",   frm_err,   m_fl[3]);
            check("R7 ovr_err",   ovr_err,   m_fl[4]);
        end
    end

    int  rise_cyc = 0, start_cyc = 0;
    logic prev_done = 0;
    always @(negedge clk) begin
        if (done_flag && !prev_done) rise_cyc = cyc;
        prev_done = done_flag;
    end

    // ---------------- stimulus helpers ----------------
    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input bit bad_par, input bit stop_v);
        @(negedge clk); rx_line = 1'b0; start_cyc = cyc;
        wait_cyc(DIV - 1);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); rx_line = b[i];
            wait_cyc(DIV - 1);
        end
        if (par_en) begin
            @(negedge clk); rx_line = (^b) ^ par_odd ^ bad_par;
            wait_cyc(DIV - 1);
        end
        @(negedge clk); rx_line = stop_v;
        wait_cyc(DIV - 1);
        @(negedge clk); rx_line = 1'b1;
        wait_cyc(2 * DIV);
    endtask

    task automatic pulse_rearm();
        @(negedge clk); rearm = 1'b1;
        @(negedge clk); rearm = 1'b0;
    endtask

    task automatic pulse_clr(input logic [4:0] m);
        @(negedge clk); flag_clr = m;
        @(negedge clk); flag_clr = '0;
    endtask

    task automatic tidy();
        pulse_rearm();
        pulse_clr(5'h1F);
    endtask

    // wait until the next posedge is the stop-bit sample
    task automatic wait_stop_edge();
        @(negedge clk);
        while (!(m_phase == 4 && m_cnt == DIV - 1 && rx_en)) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_cyc(4);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11 rx_data", rx_data, 0);
        check("R11 flags", {ovr_err, frm_err, par_err, err_flag, done_flag}, 0);
        rx_en = 1'b1;
        wait_cyc(4);

        // R1 / R2 / R4: plain frame, no parity, latency measured
        send_frame(8'hA5, 0, 1);
        check("R1 data A5", rx_data, 8'hA5);
        check("R4 done set", done_flag, 1);
        check("R4 no error", err_flag, 0);
        check("R2 start-to-flag latency", rise_cyc - start_cyc, SYNC + 1 + HALF + 9 * DIV);
        tidy();

        // R5: even parity, good then bad
        par_en = 1'b1; par_odd = 1'b0;
        send_frame(8'h3C, 0, 1);
        check("R5 even good data", rx_data, 8'h3C);
        check("R5 even good no par_err", par_err, 0);
        tidy();
        send_frame(8'h81, 1, 1);
        check("R5 bad parity par_err", par_err, 1);
        check("R5 bad parity err_flag", err_flag, 1);
        check("R5 bad parity done too", done_flag, 1);
        tidy();
        par_odd = 1'b1;
        send_frame(8'h7E, 0, 1);
        check("R5 odd good no par_err", par_err, 0);
        check("R5 odd good done", done_flag, 1);
        tidy();
        send_frame(8'h7E, 1, 1);
        check("R5 odd bad par_err", par_err, 1);
        tidy();
        par_en = 1'b0;

        // R6: framing error
        send_frame(8'h5A, 0, 0);
        check("R6 frm_err", frm_err, 1);
        check("R6 err_flag", err_flag, 1);
        check("R6 done too", done_flag, 1);
        wait_cyc(2 * DIV);
        tidy();

        // R7: overrun without re-arm
        send_frame(8'h11, 0, 1);
        pulse_clr(5'h01);
        send_frame(8'h22, 0, 1);
        check("R7 ovr_err", ovr_err, 1);
        check("R7 err_flag", err_flag, 1);
        check("R7 no done on overrun", done_flag, 0);
        check("R1 data loaded on overrun", rx_data, 8'h22);
        tidy();
        send_frame(8'h33, 0, 1);
        check("R7 rearmed frame no ovr", ovr_err, 0);
        check("R7 rearmed frame done", done_flag, 1);
        pulse_clr(5'h1F);

        // R8: re-arm on the stop-sample edge (pending still set from 0x33)
        fork
            send_frame(8'h44, 0, 1);
            begin wait_stop_edge(); rearm = 1'b1; @(negedge clk); rearm = 1'b0; end
        join
        check("R8 race counts as overrun", ovr_err, 1);
        check("R8 race no done", done_flag, 0);
        pulse_clr(5'h1F);
        send_frame(8'h45, 0, 1);
        check("R8 pending survived race", ovr_err, 1);
        tidy();

        // R9: selective clear and set-wins
        par_en = 1'b1;
        send_frame(8'h0F, 1, 1);
        pulse_clr(5'h04);
        check("R9 par cleared", par_err, 0);
        check("R9 err kept", err_flag, 1);
        check("R9 done kept", done_flag, 1);
        tidy();
        par_en = 1'b0;
        fork
            send_frame(8'h66, 0, 1);
            begin wait_stop_edge(); flag_clr = 5'h01; @(negedge clk); flag_clr = '0; end
        join
        check("R9 set beats clear", done_flag, 1);
        tidy();

        // R3: short glitch on the line
        @(negedge clk); rx_line = 1'b0;
        wait_cyc(2);
        @(negedge clk); rx_line = 1'b1;
        wait_cyc(12 * DIV);
        check("R3 glitch no done", done_flag, 0);
        check("R3 glitch data kept", rx_data, 8'h66);
        send_frame(8'hC3, 0, 1);
        check("R3 next frame aligned", rx_data, 8'hC3);
        tidy();

        // R10: disabled receiver, then abort mid-frame
        rx_en = 1'b0;
        send_frame(8'h99, 0, 1);
        check("R10 disabled no done", done_flag, 0);
        check("R10 disabled data kept", rx_data, 8'hC3);
        rx_en = 1'b1;
        fork
            send_frame(8'h00, 0, 1);
            begin wait_cyc(4 * DIV); rx_en = 1'b0; end
        join
        check("R10 aborted no done", done_flag, 0);
        rx_en = 1'b1;
        wait_cyc(2 * DIV);
        tidy();
        send_frame(8'hE7, 0, 1);
        check("R10 after re-enable data", rx_data, 8'hE7);
        check("R10 after re-enable done", done_flag, 1);

        wait_cyc(10);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule